// File: doc/BRIEF.md
# Two-Channel Ternary Bridge Control Core

This block is the digital control core of a two-channel switching output stage. Each channel has two logic-level PWM inputs, A and B, and four gate enables: a high switch and a low switch on the positive leg, and a high switch and a low switch on the negative leg. In the default stereo bridge mode the A/B pair is decoded into three levels. The load is driven positive or negative, or it is damped with both legs held at ground. A mode select also gives a parallel mono mode, in which both bridges switch identically from the left input pair. A third mode gives four independent half-bridge legs, each following its own input bit.

The core also holds the protection logic. An over-current comparator flag and a thermal shutdown decision together form the fault condition. Thermal shutdown is taken from a digital temperature code in °C and has hysteresis. A fault switches every output off at once and pulls the active-low fault output low. The fault stays latched until the tristate input goes low and then high again while the fault condition is absent. A thermal warning output, an under-voltage lockout that clears itself, a power-down input and the tristate input can each force the outputs off. The PWM path is combinational. Only the protection state is registered.

Top module: `bridge_ctrl`

## Requirements
- R1: While `hiz_n` is 0, all eight gate enables are 0, whatever the PWM inputs and the mode are.
- R2: In stereo mode (`mode`=00) each channel is decoded independently. A=1,B=0 gives gate code 1001 and A=0,B=1 gives 0110. A=0,B=0 gives the damped code 0101. The gate code bit order is [3] positive-high, [2] positive-low, [1] negative-high, [0] negative-low. No leg ever has both its switches on.
- R3: In stereo mode, A=1,B=1 gives the damped code 0101.
- R4: In mono mode (`mode`=01) both bridges are decoded from the left A/B pair, and the right inputs have no effect.
- R5: In half-bridge mode (`mode`=10) each leg follows its own bit: left A drives the left positive leg, left B the left negative leg, right A the right positive leg and right B the right negative leg. A bit of 1 selects the high switch and 0 the low switch.
- R6: The reserved mode (`mode`=11) keeps all gate enables at 0.
- R7: When `ocp_flag` is 1, all gates are 0 and `fault_n` is 0 in that same cycle. From the next clock edge the fault is latched.
- R8: A latched fault clears only on a clock edge where `hiz_n` is 1, `hiz_n` was 0 at the edge before, and no fault condition is present. If the condition is still present at the rising edge, the fault stays latched.
- R9: `warn_n` is 0 exactly when `temp_code` is at or above 130.
- R10: Thermal shutdown becomes a fault condition when `temp_code` is at or above 150. The condition holds until `temp_code` reaches 125 or lower.
- R11: While `uvlo_flag` is 1, all gates are 0 and `fault_n` is unaffected. Outputs return as soon as it clears, with no tristate toggle.
- R12: While `pwr_en` is 0, all gates are 0.
- R13: After reset no fault is latched and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 stereo, 01 mono, 10 half-bridge, 11 reserved |
| hiz_n | input | 1 | 0 forces all switches off; its low-to-high toggle clears a latched fault |
| pwr_en | input | 1 | 0 powers the output stage down |
| l_a | input | 1 | Left channel input A |
| l_b | input | 1 | Left channel input B |
| r_a | input | 1 | Right channel input A |
| r_b | input | 1 | Right channel input B |
| ocp_flag | input | 1 | Over-current comparator flag |
| uvlo_flag | input | 1 | Supply below lockout threshold |
| temp_code | input | TEMP_W | Junction temperature in °C |
| gate_l | output | 4 | Left gate enables {P-hi, P-lo, N-hi, N-lo} |
| gate_r | output | 4 | Right gate enables {P-hi, P-lo, N-hi, N-lo} |
| fault_n | output | 1 | Active-low fault indicator |
| warn_n | output | 1 | Active-low thermal warning |

## Verification
The delicate cycle is the one where the tristate input returns high while the fault condition is still present. The clear and the re-latch then compete at one edge, and the re-latch must win. The bench provokes this in two ways. It holds the over-current flag through a full low-high toggle of `hiz_n`. It also parks the temperature at 126, one step inside the hysteresis band, during a toggle. In both cases `fault_n` must still be 0 after the rising edge. A second toggle made once the condition is gone must then restore the decoded outputs.

// File: rtl/bridge_ctrl.sv
module bridge_ctrl #(
  parameter int TEMP_W = 8,
  parameter int WARN_C = 130,
  parameter int SHUT_C = 150,
  parameter int HYST_C = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              hiz_n,
  input  logic              pwr_en,
  input  logic              l_a,
  input  logic              l_b,
  input  logic              r_a,
  input  logic              r_b,
  input  logic              ocp_flag,
  input  logic              uvlo_flag,
  input  logic [TEMP_W-1:0] temp_code,
  output logic [3:0]        gate_l,
  output logic [3:0]        gate_r,
  output logic              fault_n,
  output logic              warn_n
);
  localparam logic [TEMP_W-1:0] WARN_T = TEMP_W'(WARN_C);
  localparam logic [TEMP_W-1:0] SHUT_T = TEMP_W'(SHUT_C);
  localparam logic [TEMP_W-1:0] REL_T  = TEMP_W'(SHUT_C - HYST_C);

  localparam logic [1:0] M_STEREO = 2'b00;
  localparam logic [1:0] M_MONO   = 2'b01;
  localparam logic [1:0] M_HALF   = 2'b10;

  function automatic logic [3:0] tern(input logic a, input logic b);
    case ({a, b})
      2'b10:   return 4'b1001;
      2'b01:   return 4'b0110;
      default: return 4'b0101;
    endcase
  endfunction

  function automatic logic [3:0] halfb(input logic a, input logic b);
    return {a, ~a, b, ~b};
  endfunction

  logic [3:0] raw_l, raw_r;
  logic       therm_q, therm_trip, fault_now, fault_q, low_seen, drive_en;

  always_comb begin
    case (mode)
      M_STEREO: begin raw_l = tern(l_a, l_b);  raw_r = tern(r_a, r_b);  end
      M_MONO:   begin raw_l = tern(l_a, l_b);  raw_r = tern(l_a, l_b);  end
      M_HALF:   begin raw_l = halfb(l_a, l_b); raw_r = halfb(r_a, r_b); end
      default:  begin raw_l = 4'b0000;         raw_r = 4'b0000;         end
    endcase
  end

  assign therm_trip = (temp_code >= SHUT_T) || (therm_q && (temp_code > REL_T));
  assign fault_now  = ocp_flag || therm_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_q  <= 1'b0;
      fault_q  <= 1'b0;
      low_seen <= 1'b0;
    end else begin
      therm_q  <= therm_trip;
      low_seen <= fault_q && !hiz_n;
      if (fault_now)
        fault_q <= 1'b1;
      else if (fault_q && low_seen && hiz_n)
        fault_q <= 1'b0;
    end
  end

  assign drive_en = hiz_n && pwr_en && !uvlo_flag && !fault_q && !fault_now;
  assign gate_l   = drive_en ? raw_l : 4'b0000;
  assign gate_r   = drive_en ? raw_r : 4'b0000;
  assign fault_n  = !(fault_q || fault_now);
  assign warn_n   = !(temp_code >= WARN_T);

  assert_hiz_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz_n |-> (gate_l == 4'b0000 && gate_r == 4'b0000));

  assert_no_shoot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_l[3] && gate_l[2]) && !(gate_l[1] && gate_l[0]) &&
    !(gate_r[3] && gate_r[2]) && !(gate_r[1] && gate_r[0]));

  assert_ocp_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_flag |-> (!fault_n && gate_l == 4'b0000 && gate_r == 4'b0000));

  assert_ocp_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_flag |=> !fault_n);

  assert_no_clear_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !hiz_n) |=> !fault_n);

  assert_shut_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= SHUT_T) |-> !fault_n);

  assert_uvlo_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_flag |-> (gate_l == 4'b0000 && gate_r == 4'b0000));

  assert_pwrdn_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (gate_l == 4'b0000 && gate_r == 4'b0000));
endmodule

// File: tb/test_bridge_ctrl.sv
module test_bridge_ctrl;
  localparam int CLK_P = 10;
  localparam logic [3:0] POS = 4'b1001, NEG = 4'b0110, DMP = 4'b0101, OFF = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic hiz_n = 1'b1, pwr_en = 1'b1, l_a = 1'b1, l_b = 1'b0, r_a = 1'b0, r_b = 1'b1;
  logic ocp_flag = 1'b0, uvlo_flag = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic [3:0] gate_l, gate_r;
  logic fault_n, warn_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bridge_ctrl i_bridge_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hiz_n(hiz_n), .pwr_en(pwr_en),
    .l_a(l_a), .l_b(l_b), .r_a(r_a), .r_b(r_b), .ocp_flag(ocp_flag),
    .uvlo_flag(uvlo_flag), .temp_code(temp_code), .gate_l(gate_l),
    .gate_r(gate_r), .fault_n(fault_n), .warn_n(warn_n));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive_edge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R13 gates", {gate_l, gate_r}, {POS, NEG});
    check("R13 fault_n", {7'd0, fault_n}, 8'd1);
    check("R13 warn_n", {7'd0, warn_n}, 8'd1);
  endtask

  task automatic t_hiz();
    drive_edge(); hiz_n = 1'b0; #1;
    check("R1 stereo", {gate_l, gate_r}, {OFF, OFF});
    mode = 2'b10; #1;
    check("R1 half", {gate_l, gate_r}, {OFF, OFF});
    mode = 2'b00; hiz_n = 1'b1; #1;
  endtask

  task automatic t_stereo();
    drive_edge();
    l_a = 0; l_b = 0; r_a = 1; r_b = 0; #1;
    check("R2 damp/pos", {gate_l, gate_r}, {DMP, POS});
    l_a = 0; l_b = 1; r_a = 0; r_b = 0; #1;
    check("R2 neg/damp", {gate_l, gate_r}, {NEG, DMP});
    l_a = 1; l_b = 1; r_a = 1; r_b = 1; #1;
    check("R3 both high damped", {gate_l, gate_r}, {DMP, DMP});
  endtask

  task automatic t_mono();
    drive_edge(); mode = 2'b01;
    l_a = 1; l_b = 0; r_a = 0; r_b = 1; #1;
    check("R4 mono pos", {gate_l, gate_r}, {POS, POS});
    l_a = 0; l_b = 1; r_a = 1; r_b = 0; #1;
    check("R4 mono neg", {gate_l, gate_r}, {NEG, NEG});
    mode = 2'b00; #1;
  endtask

  task automatic t_half();
    drive_edge(); mode = 2'b10;
    l_a = 1; l_b = 1; r_a = 0; r_b = 1; #1;
    check("R5 half a", {gate_l, gate_r}, {4'b1010, 4'b0110});
    l_a = 1; l_b = 0; r_a = 0; r_b = 0; #1;
    check("R5 half b", {gate_l, gate_r}, {4'b1001, 4'b0101});
    mode = 2'b11; #1;
    check("R6 reserved", {gate_l, gate_r}, {OFF, OFF});
    mode = 2'b00; l_a = 1; l_b = 0; r_a = 0; r_b = 1; #1;
  endtask

  task automatic toggle_hiz();
    drive_edge(); hiz_n = 1'b0; tick();
    drive_edge(); hiz_n = 1'b1; tick();
  endtask

  task automatic t_ocp();
    drive_edge(); ocp_flag = 1'b1; #1;
    check("R7 same-cycle off", {gate_l, gate_r, 7'd0, fault_n}[8:1], {OFF, OFF});
    check("R7 fault_n low", {7'd0, fault_n}, 8'd0);
    tick();
    drive_edge(); ocp_flag = 1'b0; #1;
    check("R7 latched", {gate_l, gate_r}, {OFF, OFF});
    check("R7 latched fault_n", {7'd0, fault_n}, 8'd0);
    drive_edge(); ocp_flag = 1'b1;
    toggle_hiz();
    drive_edge(); ocp_flag = 1'b0; tick();
    check("R8 relatch on toggle", {7'd0, fault_n}, 8'd0);
    check("R8 relatch gates", {gate_l, gate_r}, {OFF, OFF});
    toggle_hiz();
    check("R8 cleared fault_n", {7'd0, fault_n}, 8'd1);
    check("R8 cleared gates", {gate_l, gate_r}, {POS, NEG});
  endtask

  task automatic t_thermal();
    drive_edge(); temp_code = 8'd129; #1;
    check("R9 below warn", {7'd0, warn_n}, 8'd1);
    temp_code = 8'd130; #1;
    check("R9 at warn", {7'd0, warn_n}, 8'd0);
    temp_code = 8'd149; tick();
    check("R10 149 no fault", {7'd0, fault_n}, 8'd1);
    drive_edge(); temp_code = 8'd150; #1;
    check("R10 shutdown", {gate_l, gate_r, 7'd0, fault_n}[8:0], {OFF, OFF, 1'b0});
    tick();
    drive_edge(); temp_code = 8'd126;
    toggle_hiz();
    check("R10 hysteresis holds", {7'd0, fault_n}, 8'd0);
    drive_edge(); temp_code = 8'd125;
    toggle_hiz();
    check("R10 released", {7'd0, fault_n}, 8'd1);
    check("R10 gates back", {gate_l, gate_r}, {POS, NEG});
    drive_edge(); temp_code = 8'd25;
  endtask

  task automatic t_uvlo_pwr();
    drive_edge(); uvlo_flag = 1'b1; #1;
    check("R11 uvlo off", {gate_l, gate_r}, {OFF, OFF});
    check("R11 fault_n kept", {7'd0, fault_n}, 8'd1);
    tick();
    drive_edge(); uvlo_flag = 1'b0; #1;
    check("R11 auto recover", {gate_l, gate_r}, {POS, NEG});
    drive_edge(); pwr_en = 1'b0; #1;
    check("R12 power down", {gate_l, gate_r}, {OFF, OFF});
    tick();
    drive_edge(); pwr_en = 1'b1; #1;
    check("R12 power up", {gate_l, gate_r}, {POS, NEG});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    drive_edge(); rst_n = 1'b1; tick();
    t_reset();
    t_hiz();
    t_stereo();
    t_mono();
    t_half();
    t_ocp();
    t_thermal();
    t_uvlo_pwr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule